// File: doc/BRIEF.md
# Power Switch Sequencer with Supply-Threshold Handshake

This block controls the header or footer switch of one power domain that can be turned off. A request input starts power-up. The switch is built from `SEG_N` parallel segments. The block turns them on one at a time, with `STEP_CYC` clock cycles between steps, so the gate of the whole switch rises slowly and the inrush current stays small. A clocked comparator reports whether the domain's local supply has crossed its threshold. Its result is valid only at a clock edge, so the block samples it only there.

When every segment is on, the block waits for the comparator flag to be high on two edges in a row. It then sets a set-reset style completion flag, which drives the acknowledge output. The flag stays set for as long as the request is held. If the threshold is not reached within `TMO_CYC` cycles after the last segment turns on, a sticky error output rises. Dropping the request turns off all segments at once and clears the acknowledge and the error. A synchronous, active-high reset forces everything off.

States: `PG_OFF`, `PG_RAMP`, `PG_WAIT_VDD`, `PG_ON`, `PG_RAMP_DOWN`.

Transitions:
- `PG_OFF` goes to `PG_RAMP` on request (or straight to `PG_WAIT_VDD` when `SEG_N` is 1).
- `PG_RAMP` goes to `PG_WAIT_VDD` on the step that enables the last segment.
- `PG_WAIT_VDD` goes to `PG_ON` when the filtered threshold is seen.
- `PG_RAMP`, `PG_WAIT_VDD` and `PG_ON` go to `PG_RAMP_DOWN` when the request falls.
- `PG_RAMP_DOWN` always goes to `PG_OFF` after one cycle.

Top module: `pwr_gate_seq`

## Requirements
- R1: With `rst` high at a clock edge, the outputs after that edge are `seg_en` all zero, `pwr_ack` low and `tmo_err` low, and the state is `PG_OFF`.
- R2: In `PG_OFF` with `pwr_req` low, `seg_en` stays zero and `pwr_ack` stays low, whatever the value of `vdd_ok`.
- R3: The edge that samples `pwr_req` high in `PG_OFF` sets `seg_en[0]`. After that, the next higher bit turns on every `STEP_CYC` edges (thermometer code, bit i means segment i is on) until all `SEG_N` bits are set. The count of enabled segments never grows by more than one per edge.
- R4: `pwr_ack` rises only in `PG_WAIT_VDD`. It rises at the second of two consecutive edges that both sample `vdd_ok` high. A single high sample never sets it, and a high `vdd_ok` during `PG_RAMP` does not shorten the ramp.
- R5: Once `pwr_ack` is set, it and all `seg_en` bits stay high while `pwr_req` stays high, even if `vdd_ok` falls.
- R6: An edge that samples `pwr_req` low in `PG_RAMP`, `PG_WAIT_VDD` or `PG_ON` clears `seg_en`, `pwr_ack` and `tmo_err` at that edge and enters `PG_RAMP_DOWN`. The next edge enters `PG_OFF` even if `pwr_req` is high again, so a new ramp starts one edge after that at the earliest.
- R7: If `PG_WAIT_VDD` is entered and the threshold is not seen, `tmo_err` rises at the `TMO_CYC`-th edge after the entry edge. It stays high until the request is dropped or reset is applied, and a later threshold detection still raises `pwr_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the comparator sampling strobe |
| rst | input | 1 | Synchronous reset, active high |
| pwr_req | input | 1 | Power-up request, held high while power is needed |
| vdd_ok | input | 1 | Comparator flag: local supply above threshold |
| seg_en | output | SEG_N | Switch segment enables, thermometer coded |
| pwr_ack | output | 1 | Domain powered; held until the request drops |
| tmo_err | output | 1 | Threshold not reached within `TMO_CYC` cycles |

## Verification
The bench builds the block with `SEG_N`=4, `STEP_CYC`=3 and `TMO_CYC`=10. A full ramp therefore takes nine edges, and the timeout fires ten edges after the last segment turns on. These small values put a complete ramp, the one-cycle glitch rejection, the timeout followed by a late completion, a drop during the ramp and a re-request during `PG_RAMP_DOWN` all inside a run of under a hundred cycles. Each expected edge is computed from the step and timeout spacing.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
    typedef enum logic [2:0] {
        PG_OFF,
        PG_RAMP,
        PG_WAIT_VDD,
        PG_ON,
        PG_RAMP_DOWN
    } pg_state_e;
endpackage

// File: rtl/pgs_ramp.sv
module pgs_ramp #(
    parameter int SEG_N    = 8,
    parameter int STEP_CYC = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             start,
    input  logic             advance,
    output logic [SEG_N-1:0] seg_en,
    output logic             last_step
);
    localparam int CW = $clog2(SEG_N + 1);
    localparam int TW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;

    logic [CW-1:0] seg_cnt;
    logic [TW-1:0] step_tmr;
    logic          tick;
    logic          full;

    assign tick      = (step_tmr == TW'(STEP_CYC - 1));
    assign full      = (seg_cnt == CW'(SEG_N));
    assign last_step = advance && tick && (seg_cnt == CW'(SEG_N - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            seg_cnt  <= '0;
            step_tmr <= '0;
        end else if (start) begin
            seg_cnt  <= CW'(1);
            step_tmr <= '0;
        end else if (advance && !full) begin
            if (tick) begin
                seg_cnt  <= seg_cnt + 1'b1;
                step_tmr <= '0;
            end else begin
                step_tmr <= step_tmr + 1'b1;
            end
        end
    end

    for (genvar i = 0; i < SEG_N; i++) begin : g_seg
        assign seg_en[i] = (seg_cnt > CW'(i));
    end

    AST_SEG_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        ($countones(seg_en) > $countones($past(seg_en))) |->
        ($countones(seg_en) == $countones($past(seg_en)) + 1)); // R3

endmodule

// File: rtl/pgs_vdd_latch.sv
module pgs_vdd_latch (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic arm,
    input  logic vdd_ok,
    output logic set_now,
    output logic done
);
    logic vdd_q;

    always_ff @(posedge clk) begin
        if (rst) vdd_q <= 1'b0;
        else     vdd_q <= vdd_ok;
    end

    // two consecutive high samples required before the latch is set
    assign set_now = arm && vdd_ok && vdd_q;

    always_ff @(posedge clk) begin
        if (rst || clear) done <= 1'b0;
        else if (set_now) done <= 1'b1;
    end

    AST_ACK_TWO_SAMPLES: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(vdd_ok) && $past(vdd_ok, 2) && $past(arm))); // R4

endmodule

// File: rtl/pgs_timeout.sv
module pgs_timeout #(
    parameter int TMO_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic err
);
    localparam int KW = (TMO_CYC > 1) ? $clog2(TMO_CYC) : 1;

    logic [KW-1:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wait_cnt <= '0;
            err      <= 1'b0;
        end else if (run && !err) begin
            if (wait_cnt == KW'(TMO_CYC - 1)) err <= 1'b1;
            else                              wait_cnt <= wait_cnt + 1'b1;
        end
    end

    AST_ERR_ONLY_WAITING: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> $past(run)); // R7

endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq #(
    parameter int SEG_N    = 8,
    parameter int STEP_CYC = 4,
    parameter int TMO_CYC  = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwr_req,
    input  logic             vdd_ok,
    output logic [SEG_N-1:0] seg_en,
    output logic             pwr_ack,
    output logic             tmo_err
);
    import pgs_pkg::*;

    pg_state_e state, state_nx;

    logic start, advance, arm, run, drop;
    logic last_step, set_now;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= PG_OFF;
        else     state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            PG_OFF: begin
                if (pwr_req) state_nx = (SEG_N == 1) ? PG_WAIT_VDD : PG_RAMP;
            end
            PG_RAMP: begin
                if (!pwr_req)      state_nx = PG_RAMP_DOWN;
                else if (last_step) state_nx = PG_WAIT_VDD;
            end
            PG_WAIT_VDD: begin
                if (!pwr_req)    state_nx = PG_RAMP_DOWN;
                else if (set_now) state_nx = PG_ON;
            end
            PG_ON: begin
                if (!pwr_req) state_nx = PG_RAMP_DOWN;
            end
            PG_RAMP_DOWN: state_nx = PG_OFF;
            default:      state_nx = PG_OFF;
        endcase
    end

    // control strobes decoded from the state
    always_comb begin
        start   = 1'b0;
        advance = 1'b0;
        arm     = 1'b0;
        drop    = 1'b0;
        unique case (state)
            PG_OFF:       start = pwr_req;
            PG_RAMP:      begin advance = pwr_req; drop = !pwr_req; end
            PG_WAIT_VDD:  begin arm = pwr_req;     drop = !pwr_req; end
            PG_ON:        drop = !pwr_req;
            PG_RAMP_DOWN: ;
            default:      ;
        endcase
        run = arm && !set_now;
    end

    pgs_ramp #(.SEG_N(SEG_N), .STEP_CYC(STEP_CYC)) u_ramp (
        .clk       (clk),
        .rst       (rst),
        .clear     (drop),
        .start     (start),
        .advance   (advance),
        .seg_en    (seg_en),
        .last_step (last_step)
    );

    pgs_vdd_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .clear   (drop),
        .arm     (arm),
        .vdd_ok  (vdd_ok),
        .set_now (set_now),
        .done    (pwr_ack)
    );

    pgs_timeout #(.TMO_CYC(TMO_CYC)) u_tmo (
        .clk   (clk),
        .rst   (rst),
        .clear (drop),
        .run   (run),
        .err   (tmo_err)
    );

    AST_ACK_ALL_SEGMENTS: assert property (@(posedge clk) disable iff (rst)
        pwr_ack |-> (&seg_en)); // R5

    AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!pwr_req && (state inside {PG_RAMP, PG_WAIT_VDD, PG_ON})) |=>
        (seg_en == '0 && !pwr_ack && !tmo_err && state == PG_RAMP_DOWN)); // R6

    AST_DOWN_TO_OFF: assert property (@(posedge clk) disable iff (rst)
        (state == PG_RAMP_DOWN) |=> (state == PG_OFF)); // R6

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == PG_OFF) |-> (seg_en == '0 && !pwr_ack)); // R2

endmodule

// File: tb/sim_pwr_gate_seq.sv
`timescale 1ns/1ps
module sim_pwr_gate_seq;
    localparam int N = 4;
    localparam int S = 3;
    localparam int T = 10;

    typedef struct {
        int         cyc;
        logic [N-1:0] seg;
        logic       ack;
        logic       err;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_req = 1'b0;
    logic vdd_ok = 1'b1;
    logic [N-1:0] seg_en;
    logic pwr_ack, tmo_err;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwr_gate_seq #(.SEG_N(N), .STEP_CYC(S), .TMO_CYC(T)) u0 (
        .clk(clk), .rst(rst), .pwr_req(pwr_req), .vdd_ok(vdd_ok),
        .seg_en(seg_en), .pwr_ack(pwr_ack), .tmo_err(tmo_err)
    );

    task automatic at_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic expect_at(input int c, input logic [N-1:0] s,
                             input logic a, input logic e, input string tag);
        exp_t x;
        x.cyc = c; x.seg = s; x.ack = a; x.err = e; x.tag = tag;
        sb.push_back(x);
    endtask

    // monitor: pop and compare
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            exp_t x;
            x = sb.pop_front();
            n_tests++;
            if (x.cyc < cyc) begin
                n_fail++;
                $display("FAIL %s missed cyc=%0d (now %0d)", x.tag, x.cyc, cyc);
            end else if (seg_en !== x.seg || pwr_ack !== x.ack || tmo_err !== x.err) begin
                n_fail++;
                $display("FAIL %s cyc=%0d seg=%b exp %b ack=%b exp %b err=%b exp %b",
                         x.tag, cyc, seg_en, x.seg, pwr_ack, x.ack, tmo_err, x.err);
            end
        end
    end

    initial begin
        repeat (3000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired at cyc=%0d, expected end of run", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1 reset state, R2 comparator ignored while off
        expect_at(4, 4'b0000, 0, 0, "R1");
        expect_at(6, 4'b0000, 0, 0, "R2");
        at_cyc(3); rst = 1'b0;
        // R3 ramp with comparator high all along (R4: ramp not shortened)
        at_cyc(10); pwr_req = 1'b1;
        expect_at(11, 4'b0001, 0, 0, "R3");
        expect_at(13, 4'b0001, 0, 0, "R3");
        expect_at(14, 4'b0011, 0, 0, "R3");
        expect_at(17, 4'b0111, 0, 0, "R3");
        expect_at(20, 4'b1111, 0, 0, "R4");
        expect_at(21, 4'b1111, 1, 0, "R4");
        // R5 hold while comparator falls
        at_cyc(22); vdd_ok = 1'b0;
        expect_at(24, 4'b1111, 1, 0, "R5");
        // R6 drop in ON, re-request during ramp-down
        at_cyc(26); pwr_req = 1'b0;
        expect_at(27, 4'b0000, 0, 0, "R6");
        at_cyc(27); pwr_req = 1'b1;
        expect_at(28, 4'b0000, 0, 0, "R6");
        expect_at(29, 4'b0001, 0, 0, "R6");
        expect_at(38, 4'b1111, 0, 0, "R3");
        // R4 single-sample glitch rejected
        at_cyc(38); vdd_ok = 1'b1;
        at_cyc(39); vdd_ok = 1'b0;
        expect_at(41, 4'b1111, 0, 0, "R4");
        // R7 timeout at entry+T, then late completion
        expect_at(47, 4'b1111, 0, 0, "R7");
        expect_at(48, 4'b1111, 0, 1, "R7");
        at_cyc(50); vdd_ok = 1'b1;
        expect_at(51, 4'b1111, 0, 1, "R7");
        expect_at(52, 4'b1111, 1, 1, "R7");
        // R1 reset while powered
        at_cyc(55); rst = 1'b1;
        expect_at(56, 4'b0000, 0, 0, "R1");
        at_cyc(57); rst = 1'b0;
        expect_at(58, 4'b0001, 0, 0, "R3");
        // R6 drop during ramp
        at_cyc(60); pwr_req = 1'b0;
        expect_at(61, 4'b0000, 0, 0, "R6");
        at_cyc(62); vdd_ok = 1'b0;
        // R4 comparator rising after last segment
        at_cyc(63); pwr_req = 1'b1;
        expect_at(64, 4'b0001, 0, 0, "R3");
        expect_at(73, 4'b1111, 0, 0, "R3");
        at_cyc(73); vdd_ok = 1'b1;
        expect_at(74, 4'b1111, 0, 0, "R4");
        expect_at(75, 4'b1111, 1, 0, "R4");
        at_cyc(80);
        while (sb.size() > 0) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule